// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns refresh for an asynchronous page-mode DRAM. After reset it waits out the power-up pause. It then runs a fixed burst of CAS-before-RAS refresh cycles and raises `ready`. Only then may the access sequencer start normal traffic. From that point an interval timer spreads the refresh work evenly over the refresh period. Each expiry adds one owed refresh to a saturating counter. An owed refresh is served as soon as the sequencer grants the bus.

Whenever the block holds the bus it drives the row strobe, the column strobe and the write strobe itself. The write strobe is never driven low, so the DRAM's test function cannot be entered by mistake.

A self-refresh request is served in three steps:
- An ordinary refresh runs first.
- The block parks the DRAM in a CAS-before-RAS cycle and holds the row strobe low for at least a minimum time.
- On an exit request, the block waits out the longer self-refresh precharge and runs one more ordinary refresh before it releases the bus.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `bus_req` stays low and `ras_n`, `cas_n` and `we_n` stay high for at least `INIT_WAIT_CYC` cycles. `ready` is low throughout this pause.
- R2: After the pause, exactly `INIT_REFS` refresh cycles run before `ready` goes high. A self-refresh request made before `ready` is high is ignored.
- R3: In every refresh, `cas_n` is low for at least `T_CSR` cycles before `ras_n` falls and stays low while `ras_n` is low. `we_n` is high at all times.
- R4: The strobes move only after `bus_gnt` has answered `bus_req`. An ordinary refresh holds `ras_n` low for exactly `T_RAS` cycles. Before `ras_n` falls again, it is high for at least `T_RP` cycles.
- R5: Once `ready` is high, one refresh is owed every INTERVAL cycles. INTERVAL is the refresh period divided by the row count: 4096 rows over `PERIOD_CYC_4K` when `ROWS_4K`=1, and 2048 rows over `PERIOD_CYC_2K` otherwise. With the bus always granted, successive refresh starts are exactly INTERVAL cycles apart.
- R6: While the grant is withheld, owed refreshes accumulate up to `MAX_OWED`, and further expiries are dropped. When the grant returns, the owed refreshes run back to back.
- R7: A one-cycle pulse on `sr_enter` while `ready` is high is served as follows:
  - one ordinary refresh runs first;
  - then a CAS-before-RAS cycle holds `ras_n` low for at least `SR_MIN_CYC` cycles;
  - `ready` is low during the self-refresh.
- R8: Self-refresh ends on the first `sr_exit` seen while `ras_n` is held low, but never before `SR_MIN_CYC` cycles have passed. `ras_n` then stays high for at least `T_RPS` cycles. One ordinary refresh follows at once, after which `ready` returns high.
- R9: `sr_exit` pulsed outside self-refresh has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Memory bus granted to this block |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| bus_req | output | 1 | Memory bus wanted |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| ready | output | 1 | Normal accesses allowed |

## Verification
The refresh scheduling is exercised with four grant and request patterns, and each one separates a different part of the logic.
- An always-present grant gives refresh starts exactly one interval apart, which tests the timer alone.
- A grant withheld for five intervals, then restored, must yield exactly the saturated number of back-to-back refreshes. This separates saturation from counting every expiry or losing them all.
- A self-refresh exit requested early must still produce a row-strobe hold of the minimum length. An exit requested late must produce a hold that lasts until the request, which separates the minimum timer from the exit latch.
- Stray `sr_enter` during the power-up pause and stray `sr_exit` while idle must leave the refresh pattern and `ready` unchanged.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter bit          ROWS_4K       = 1'b1,
  parameter int unsigned PERIOD_CYC_4K = 6_400_000,
  parameter int unsigned PERIOD_CYC_2K = 3_200_000,
  parameter int unsigned INIT_WAIT_CYC = 20_000,
  parameter int unsigned INIT_REFS     = 8,
  parameter int unsigned MAX_OWED      = 4,
  parameter int unsigned SR_MIN_CYC    = 10_000,
  parameter int unsigned T_CSR         = 1,
  parameter int unsigned T_RAS         = 5,
  parameter int unsigned T_RP          = 4,
  parameter int unsigned T_RPS         = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic bus_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);
  localparam int unsigned ROWS     = ROWS_4K ? 4096 : 2048;
  localparam int unsigned INTERVAL = (ROWS_4K ? PERIOD_CYC_4K : PERIOD_CYC_2K) / ROWS;
  localparam int unsigned L1       = INIT_WAIT_CYC > SR_MIN_CYC ? INIT_WAIT_CYC : SR_MIN_CYC;
  localparam int unsigned L2       = T_RPS > T_RAS ? T_RPS : T_RAS;
  localparam int unsigned LONGEST  = L1 > L2 ? L1 : L2;
  localparam int unsigned CW       = $clog2(LONGEST + 1);
  localparam int unsigned TW       = $clog2(INTERVAL + 1);
  localparam int unsigned OW       = $clog2(MAX_OWED + 1);
  localparam int unsigned IW       = $clog2(INIT_REFS + 1);

  typedef enum logic [3:0] {
    ST_WAIT, ST_IDLE, ST_REQ, ST_CAS, ST_RAS, ST_PRE, ST_SR_CAS, ST_SR_HOLD, ST_SR_PRE
  } st_t;

  st_t st, st_nxt;
  logic [CW-1:0] cnt, limit;
  logic [TW-1:0] tmr;
  logic [OW-1:0] owed, owed_nxt;
  logic [IW-1:0] init_left;
  logic init_done, sr_pend, in_sr, exit_seen;
  logic last, pre_done, tick;

  always_comb begin
    case (st)
      ST_WAIT:           limit = CW'(INIT_WAIT_CYC);
      ST_CAS, ST_SR_CAS: limit = CW'(T_CSR);
      ST_RAS:            limit = CW'(T_RAS);
      ST_PRE:            limit = CW'(T_RP);
      ST_SR_HOLD:        limit = CW'(SR_MIN_CYC);
      ST_SR_PRE:         limit = CW'(T_RPS);
      default:           limit = CW'(1);
    endcase
  end

  assign last     = (cnt == limit - CW'(1));
  assign pre_done = (st == ST_PRE) && last;
  assign tick     = init_done && !in_sr && (tmr == TW'(INTERVAL - 1));

  always_comb begin
    st_nxt = st;
    case (st)
      ST_WAIT:    if (last) st_nxt = ST_REQ;
      ST_IDLE:    if (!init_done || owed != '0 || sr_pend) st_nxt = ST_REQ;
      ST_REQ:     if (bus_gnt) st_nxt = ST_CAS;
      ST_CAS:     if (last) st_nxt = ST_RAS;
      ST_RAS:     if (last) st_nxt = ST_PRE;
      ST_PRE:     if (last) st_nxt = sr_pend ? ST_SR_CAS : ST_IDLE;
      ST_SR_CAS:  if (last) st_nxt = ST_SR_HOLD;
      ST_SR_HOLD: if (last && (exit_seen || sr_exit)) st_nxt = ST_SR_PRE;
      ST_SR_PRE:  if (last) st_nxt = ST_CAS;
      default:    st_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    owed_nxt = owed;
    if (tick && owed != OW'(MAX_OWED)) owed_nxt = owed_nxt + OW'(1);
    if (pre_done && init_done && owed != '0) owed_nxt = owed_nxt - OW'(1);
    if (st == ST_SR_PRE && last) owed_nxt = OW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_WAIT;
      cnt       <= '0;
      tmr       <= '0;
      owed      <= '0;
      init_left <= IW'(INIT_REFS);
      init_done <= 1'b0;
      sr_pend   <= 1'b0;
      in_sr     <= 1'b0;
      exit_seen <= 1'b0;
    end else begin
      st   <= st_nxt;
      cnt  <= (st_nxt != st) ? '0 : (last ? cnt : cnt + CW'(1));
      tmr  <= (!init_done || in_sr || tick) ? '0 : tmr + TW'(1);
      owed <= owed_nxt;
      if (pre_done && !init_done) begin
        init_left <= init_left - IW'(1);
        if (init_left == IW'(1)) init_done <= 1'b1;
      end
      if (pre_done && sr_pend) sr_pend <= 1'b0;
      else if (sr_enter && init_done && !in_sr) sr_pend <= 1'b1;
      if (pre_done && sr_pend) in_sr <= 1'b1;
      else if (pre_done && in_sr) in_sr <= 1'b0;
      exit_seen <= (st == ST_SR_HOLD) && (exit_seen || sr_exit);
    end
  end

  assign bus_req = !(st == ST_WAIT || st == ST_IDLE);
  assign ras_n   = !(st == ST_RAS || st == ST_SR_HOLD);
  assign cas_n   = !(st == ST_CAS || st == ST_RAS || st == ST_SR_CAS || st == ST_SR_HOLD);
  assign we_n    = 1'b1;
  assign ready   = init_done && !in_sr;

  logic [CW-1:0] chk_lo, chk_hi, chk_age;
  logic [IW:0]   chk_falls;
  logic          chk_after_self;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_lo <= '0; chk_hi <= '0; chk_age <= '0; chk_falls <= '0; chk_after_self <= 1'b0;
    end else begin
      chk_lo  <= ras_n ? '0 : ((chk_lo == CW'(LONGEST)) ? chk_lo : chk_lo + CW'(1));
      chk_hi  <= !ras_n ? '0 : ((chk_hi == CW'(LONGEST)) ? chk_hi : chk_hi + CW'(1));
      chk_age <= (chk_age == CW'(INIT_WAIT_CYC)) ? chk_age : chk_age + CW'(1);
      if (!ras_n && chk_lo == '0 && chk_falls != {(IW+1){1'b1}}) chk_falls <= chk_falls + 1'b1;
      if (ras_n && chk_lo != '0) chk_after_self <= (chk_lo != CW'(T_RAS));
    end
  end

  assert_init_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> chk_age >= CW'(INIT_WAIT_CYC));
  assert_init_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_falls < (IW+1)'(INIT_REFS)) |-> !ready);
  assert_cas_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n) && we_n));
  assert_cas_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  assert_strobe_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> bus_req);
  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> chk_lo >= CW'(T_RAS));
  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !chk_after_self) |-> chk_hi >= CW'(T_RP));
  assert_owed_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));
  assert_self_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && chk_lo != CW'(T_RAS)) |-> chk_lo >= CW'(SR_MIN_CYC));
  assert_self_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && chk_after_self) |-> chk_hi >= CW'(T_RPS));
endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int CLK_NS = 10;
  localparam int INIT_W = 300;
  localparam int IV     = 60;
  localparam int MAXO   = 3;
  localparam int SRMIN  = 200;
  localparam int TRAS   = 5;
  localparam int TRP    = 4;
  localparam int TRPS   = 9;

  logic clk = 1'b0, rst_n = 1'b0, gnt_en = 1'b1, sr_enter = 1'b0, sr_exit = 1'b0;
  logic bus_req, ras_n, cas_n, we_n, ready;
  wire  bus_gnt = bus_req & gnt_en;

  dram_refresh_sched #(
    .ROWS_4K(1'b1), .PERIOD_CYC_4K(IV * 4096), .PERIOD_CYC_2K(IV * 2048),
    .INIT_WAIT_CYC(INIT_W), .INIT_REFS(8), .MAX_OWED(MAXO), .SR_MIN_CYC(SRMIN),
    .T_CSR(1), .T_RAS(TRAS), .T_RP(TRP), .T_RPS(TRPS)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .sr_enter(sr_enter), .sr_exit(sr_exit),
    .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int errors = 0, checks = 0;
  int expq[$];
  int cyc = 0, falls = 0, last_fall = 0, last_gap = 0;
  int lo = 0, hi = 1000, self_len = 0, fall_hi = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, after_self = 1'b0, done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_pulse(int kind);
    expq.push_back(kind);
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_falls(int n);
    while (falls < n) begin @(negedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!we_n) check(1'b0, "R3", "write strobe low", 0, 1);
      if (prev_ras && !ras_n) begin
        falls++;
        check(!cas_n && !prev_cas, "R3", "column strobe before row fall", prev_cas, 0);
        check(bus_gnt, "R4", "grant at row fall", bus_gnt, 1);
        check(hi >= (after_self ? TRPS : TRP), "R4", "precharge length", hi, after_self ? TRPS : TRP);
        fall_hi = hi;
        last_gap = cyc - last_fall;
        last_fall = cyc;
        lo = 0;
      end
      if (!prev_ras && ras_n) begin
        if (expq.size() == 0) begin
          check(1'b0, "R4", "unexpected row pulse", lo, 0);
          after_self = 1'b0;
        end else begin
          int kind;
          kind = expq.pop_front();
          if (kind == 0) check(lo == TRAS, "R4", "ordinary row pulse width", lo, TRAS);
          else begin
            check(lo >= SRMIN, "R7", "self-refresh hold", lo, SRMIN);
            self_len = lo;
          end
          after_self = (kind == 1);
        end
        hi = 0;
      end
      if (!ras_n) begin
        lo++;
        if (cas_n) check(1'b0, "R3", "column strobe rose during row low", 1, 0);
      end else hi++;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    check(!bus_req && ras_n && cas_n && we_n && !ready, "R1", "reset outputs",
          {bus_req, ras_n, cas_n, we_n, ready}, 5'b01110);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) expect_pulse(0);
    tick_n(50);
    sr_enter = 1'b1; tick_n(1); sr_enter = 1'b0;
    while (!bus_req) begin @(negedge clk); #1; end
    check(cyc >= INIT_W && cyc <= INIT_W + 2, "R1", "power-up pause length", cyc, INIT_W);
    check(falls == 0, "R1", "no refresh during pause", falls, 0);
    while (!ready) begin @(negedge clk); #1; end
    check(falls == 8, "R2", "init refresh count", falls, 8);
    check(expq.size() == 0, "R2", "init pulses consumed", expq.size(), 0);

    tick_n(IV / 3);
    check(ready && !bus_req, "R2", "early self-refresh request ignored", {ready, bus_req}, 2'b10);

    for (int k = 0; k < 3; k++) expect_pulse(0);
    f0 = falls;
    wait_falls(f0 + 1);
    sr_exit = 1'b1; tick_n(1); sr_exit = 1'b0;
    wait_falls(f0 + 2);
    check(last_gap == IV, "R5", "refresh spacing 1", last_gap, IV);
    wait_falls(f0 + 3);
    check(last_gap == IV, "R5", "refresh spacing 2", last_gap, IV);
    check(ready, "R9", "stray exit left ready high", ready, 1);

    gnt_en = 1'b0;
    f0 = falls;
    tick_n(307);
    check(falls == f0, "R4", "no refresh without grant", falls - f0, 0);
    check(bus_req, "R6", "request held while withheld", bus_req, 1);
    for (int k = 0; k < 4; k++) expect_pulse(0);
    gnt_en = 1'b1;
    tick_n(45);
    check(falls - f0 == MAXO, "R6", "owed refreshes after withheld grant", falls - f0, MAXO);
    wait_falls(f0 + MAXO + 1);

    tick_n(20);
    expect_pulse(0); expect_pulse(1); expect_pulse(0);
    f0 = falls;
    sr_enter = 1'b1; tick_n(1); sr_enter = 1'b0;
    wait_falls(f0 + 2);
    check(!ready, "R7", "ready low in self-refresh", ready, 0);
    tick_n(50);
    sr_exit = 1'b1; tick_n(1); sr_exit = 1'b0;
    check(!ras_n, "R8", "early exit deferred", ras_n, 0);
    while (!ready) begin @(negedge clk); #1; end
    check(self_len >= SRMIN && self_len <= SRMIN + 1, "R8", "hold with early exit", self_len, SRMIN);
    check(fall_hi >= TRPS && fall_hi <= TRPS + 2, "R8", "post-exit refresh follows precharge", fall_hi, TRPS);
    check(expq.size() == 0, "R8", "post-exit refresh done", expq.size(), 0);

    expect_pulse(0);
    f0 = falls;
    wait_falls(f0 + 1);
    check(last_gap > 0 && last_gap <= IV + TRAS + TRP + 6, "R5", "interval restarts after exit", last_gap, IV);

    tick_n(20);
    expect_pulse(0); expect_pulse(1); expect_pulse(0);
    f0 = falls;
    sr_enter = 1'b1; tick_n(1); sr_enter = 1'b0;
    wait_falls(f0 + 2);
    tick_n(SRMIN + 100);
    check(!ras_n && !ready, "R8", "hold continues without exit request", ras_n, 0);
    sr_exit = 1'b1; tick_n(1); sr_exit = 1'b0;
    while (!ready) begin @(negedge clk); #1; end
    check(self_len >= SRMIN + 100, "R8", "hold with late exit", self_len, SRMIN + 100);
    check(expq.size() == 0, "R7", "pre and post refresh around self-refresh", expq.size(), 0);
    tick_n(5);
    finish_run();
  end
endmodule